// File: doc/BRIEF.md
# Critical-Word-First Line Refill Engine

This block refills one cache line after a miss. The line comes from a memory built as four word-interleaved banks. On an accepted miss it spends one cycle sending the line address to the banks. It then waits out a fixed bank access time. After that it takes one word per cycle, and each word comes from the bank that the engine selects.

The words arrive in wrapped order. The word the processor missed on comes first, and the other words follow, counting up modulo the line length. The missed word is passed straight to the processor in the cycle it arrives, so the processor can restart early. The remaining words are gathered in a line buffer. The buffer is written to the cache data array in one strobe once the whole line is present.

While a refill is in progress the engine accepts no new miss. Choosing a victim line and updating the tag are handled outside this block.

Top module: `cwf_refill`

## Requirements
- R1: After reset `miss_ready_o` is 1, and `mem_req_o`, `cpu_valid_o` and `line_we_o` are 0.
- R2: A miss is accepted at a clock edge where `miss_valid_i` and `miss_ready_o` are both 1. Number the next cycle as cycle 1. `mem_req_o` is 1 in cycle 1 only, and `mem_addr_o` then equals the accepted line address.
- R3: Cycles 2 to 7 are the six bank access cycles. No word is taken during them, and `cpu_valid_o` and `line_we_o` stay 0.
- R4: In cycles 8 to 11, `mem_bank_o` selects bank (off+k) mod 4 in cycle 8+k. Here off is the accepted word offset and bank b holds word b of the line. The word is read from `mem_rdata_i` in the same cycle.
- R5: `cpu_valid_o` is 1 in cycle 8 only, for exactly one cycle. In that cycle `cpu_data_o` equals the word at the requested offset and `cpu_off_o` equals that offset.
- R6: `line_we_o` is 1 in cycle 12 only. In that cycle `line_addr_o` is the accepted line address and bits [32i+31:32i] of `line_data_o` hold word i of the line, for i = 0 to 3.
- R7: `miss_ready_o` is 0 in cycles 1 to 12. A `miss_valid_i` held high during a refill is ignored: no extra bank request is made, and the line address and data written in cycle 12 belong to the accepted miss.
- R8: `miss_ready_o` is 1 again in cycle 13. A miss presented then is accepted at the end of that cycle, so back-to-back refills run with no gap.
- R9: Asserting `rst_ni` during a refill aborts it. At once `miss_ready_o` becomes 1 and the other outputs of R1 become 0, and the next miss refills normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Miss request present |
| miss_addr_i | input | ADDR_W | Line address of the miss |
| miss_off_i | input | 2 | Word offset the processor missed on |
| miss_ready_o | output | 1 | Engine idle, miss can be accepted |
| cpu_valid_o | output | 1 | One-cycle strobe for the critical word |
| cpu_data_o | output | 32 | Critical word to the processor |
| cpu_off_o | output | 2 | Word offset of the forwarded word |
| line_we_o | output | 1 | Line write strobe to the cache data array |
| line_addr_o | output | ADDR_W | Line address being written |
| line_data_o | output | 128 | Whole line, word i at bits [32i+31:32i] |
| mem_req_o | output | 1 | Address phase to the banks |
| mem_addr_o | output | ADDR_W | Line address for the banks |
| mem_bank_o | output | 2 | Bank whose word is transferred this cycle |
| mem_rdata_i | input | 32 | Word from the selected bank |

## Verification
Refills are run for each of the four start offsets, and for the all-zero and all-one line addresses. The memory model returns a word that encodes both the address and the bank. A wrong wrap order, a swapped bank, or a word stored in the wrong buffer slot therefore shows up as a different value on the processor port or in the written line. One refill has a second miss held high while it runs, to show that the request is ignored. Another is cut off by a reset in mid-access, which tells a clean abort apart from a counter left with stale state. Back-to-back refills check that the engine is idle again in the cycle after the line write, and not a cycle late.

// File: rtl/cwf_refill_pkg.sv
package cwf_refill_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WAIT,
    ST_XFER,
    ST_WRITE
  } refill_st_e;
endpackage

// File: rtl/cwf_refill_seq.sv
module cwf_refill_seq
  import cwf_refill_pkg::*;
#(
  parameter int WORDS      = 4,
  parameter int ACCESS_CYC = 6,
  localparam int OFF_W     = $clog2(WORDS),
  localparam int CNT_MAX   = (ACCESS_CYC > WORDS) ? ACCESS_CYC : WORDS,
  localparam int CNT_W     = $clog2(CNT_MAX) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             idle_o,
  output logic             addr_ph_o,
  output logic             xfer_o,
  output logic             first_o,
  output logic [OFF_W-1:0] idx_o,
  output logic             write_o
);
  refill_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_ADDR;
      ST_ADDR: begin
        st_d  = ST_WAIT;
        cnt_d = '0;
      end
      ST_WAIT: begin
        if (cnt_q == CNT_W'(ACCESS_CYC - 1)) begin
          st_d  = ST_XFER;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_XFER: begin
        if (cnt_q == CNT_W'(WORDS - 1)) begin
          st_d  = ST_WRITE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WRITE: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign idle_o    = (st_q == ST_IDLE);
  assign addr_ph_o = (st_q == ST_ADDR);
  assign xfer_o    = (st_q == ST_XFER);
  assign first_o   = xfer_o && (cnt_q == '0);
  assign idx_o     = cnt_q[OFF_W-1:0];
  assign write_o   = (st_q == ST_WRITE);

  AST_REQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ph_o |=> !addr_ph_o); // R2
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_o |=> !write_o && idle_o); // R8
  AST_WAIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_ph_o |=> !xfer_o && !write_o); // R3
endmodule

// File: rtl/cwf_refill_linebuf.sv
module cwf_refill_linebuf #(
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [LINE_W-1:0] line_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   word_q <= '0;
      else if (wr_en_i && wr_idx_i == OFF_W'(g))     word_q <= wr_data_i;
    end
    assign line_o[g*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/cwf_refill.sv
module cwf_refill #(
  parameter int ADDR_W     = 26,
  parameter int WORD_W     = 32,
  parameter int WORDS      = 4,
  parameter int ACCESS_CYC = 6,
  localparam int OFF_W     = $clog2(WORDS),
  localparam int LINE_W    = WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic [OFF_W-1:0]  miss_off_i,
  output logic              miss_ready_o,
  output logic              cpu_valid_o,
  output logic [WORD_W-1:0] cpu_data_o,
  output logic [OFF_W-1:0]  cpu_off_o,
  output logic              line_we_o,
  output logic [ADDR_W-1:0] line_addr_o,
  output logic [LINE_W-1:0] line_data_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [OFF_W-1:0]  mem_bank_o,
  input  logic [WORD_W-1:0] mem_rdata_i
);
  logic              accept, xfer, first;
  logic [OFF_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  off_q;

  assign accept = miss_valid_i && miss_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      off_q  <= '0;
    end else if (accept) begin
      addr_q <= miss_addr_i;
      off_q  <= miss_off_i;
    end
  end

  cwf_refill_seq #(.WORDS(WORDS), .ACCESS_CYC(ACCESS_CYC)) u_seq (
    .clk_i, .rst_ni,
    .start_i   (accept),
    .idle_o    (miss_ready_o),
    .addr_ph_o (mem_req_o),
    .xfer_o    (xfer),
    .first_o   (first),
    .idx_o     (idx),
    .write_o   (line_we_o)
  );

  // wrapped order: requested word first, then upward modulo line length
  assign mem_bank_o = off_q + idx;
  assign mem_addr_o = addr_q;

  cwf_refill_linebuf #(.WORDS(WORDS), .WORD_W(WORD_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i   (xfer),
    .wr_idx_i  (mem_bank_o),
    .wr_data_i (mem_rdata_i),
    .line_o    (line_data_o)
  );

  // early restart: critical word bypasses the buffer
  assign cpu_valid_o = first;
  assign cpu_data_o  = mem_rdata_i;
  assign cpu_off_o   = off_q;
  assign line_addr_o = addr_q;

  AST_CPU_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_o |=> !cpu_valid_o); // R5
  AST_CPU_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_o |-> cpu_off_o == mem_bank_o); // R5
  AST_BANK_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer && $past(xfer) |-> mem_bank_o == OFF_W'($past(mem_bank_o) + 1'b1)); // R4
  AST_NO_BUSY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $past(miss_valid_i && miss_ready_o)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_ready_o |=> $stable(line_addr_o)); // R7
endmodule

// File: tb/cwf_refill_tb.sv
module cwf_refill_tb;
  localparam int ADDR_W = 26;
  localparam int NVEC   = 6;
  // {inject busy miss, line address, offset}
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b0, 26'h0000000, 2'd0},
    {1'b0, 26'h1234567, 2'd1},
    {1'b1, 26'h2ABCDEF, 2'd2},
    {1'b0, 26'h0F0F0F0, 2'd3},
    {1'b0, 26'h3FFFFFF, 2'd3},
    {1'b1, 26'h1555555, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic miss_valid = 1'b0;
  logic [ADDR_W-1:0] miss_addr = '0;
  logic [1:0] miss_off = '0;
  logic miss_ready, cpu_valid, line_we, mem_req;
  logic [31:0] cpu_data, mem_rdata;
  logic [1:0] cpu_off, mem_bank;
  logic [ADDR_W-1:0] line_addr, mem_addr;
  logic [127:0] line_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] mem_word(logic [ADDR_W-1:0] a, logic [1:0] b);
    return {4'hA, a, b} ^ {b, 30'h0};
  endfunction

  assign mem_rdata = mem_word(mem_addr, mem_bank);

  cwf_refill u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .miss_valid_i(miss_valid), .miss_addr_i(miss_addr), .miss_off_i(miss_off),
    .miss_ready_o(miss_ready),
    .cpu_valid_o(cpu_valid), .cpu_data_o(cpu_data), .cpu_off_o(cpu_off),
    .line_we_o(line_we), .line_addr_o(line_addr), .line_data_o(line_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_bank_o(mem_bank),
    .mem_rdata_i(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_outs(input string req);
    chk(miss_ready == 1'b1, req, miss_ready, 1);
    chk(mem_req == 1'b0 && cpu_valid == 1'b0 && line_we == 1'b0, req,
        {mem_req, cpu_valid, line_we}, 0);
  endtask

  // entered at a negedge while idle; returns at negedge of cycle 13
  task automatic refill(input logic [ADDR_W-1:0] a, input logic [1:0] off, input bit busy);
    logic [127:0] exp_line;
    for (int i = 0; i < 4; i++) exp_line[32*i +: 32] = mem_word(a, 2'(i));
    chk(miss_ready == 1'b1, "R8 ready before accept", miss_ready, 1);
    miss_valid = 1'b1; miss_addr = a; miss_off = off;
    @(posedge clk);
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (c == 1) miss_valid = 1'b0;
      chk(miss_ready == 1'b0, "R7 busy", miss_ready, 0);
      chk(mem_req == (c == 1), "R2 req timing", mem_req, c == 1);
      if (c == 1) chk(mem_addr == a, "R2 address", mem_addr, a);
      if (c >= 2 && c <= 7) chk(cpu_valid == 1'b0 && line_we == 1'b0, "R3 access wait",
                                {cpu_valid, line_we}, 0);
      if (c >= 8 && c <= 11) chk(mem_bank == 2'(off + 2'(c - 8)), "R4 wrap order", mem_bank,
                                 2'(off + 2'(c - 8)));
      chk(cpu_valid == (c == 8), "R5 cpu strobe", cpu_valid, c == 8);
      if (c == 8) begin
        chk(cpu_data == mem_word(a, off), "R5 critical word", cpu_data, mem_word(a, off));
        chk(cpu_off == off, "R5 cpu offset", cpu_off, off);
      end
      chk(line_we == (c == 12), "R6 write timing", line_we, c == 12);
      if (c == 12) begin
        chk(line_addr == a, "R6 R7 line address", line_addr, a);
        chk(line_data == exp_line, "R6 line data", line_data, exp_line);
      end
      if (busy && c == 3) begin
        miss_valid = 1'b1; miss_addr = ~a; miss_off = ~off;
      end
      if (busy && c == 12) miss_valid = 1'b0;
    end
    @(negedge clk);
    chk(miss_ready == 1'b1, "R8 ready in cycle 13", miss_ready, 1);
    chk(mem_req == 1'b0, "R7 no extra request", mem_req, 0);
  endtask

  initial begin
    #1;
    idle_outs("R1 in reset");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    idle_outs("R1 after reset");
    for (int v = 0; v < NVEC; v++)
      refill(VEC[v][27:2], VEC[v][1:0], VEC[v][28]);
    // R9: reset in mid-access
    miss_valid = 1'b1; miss_addr = 26'h0ABCDE0; miss_off = 2'd2;
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(miss_ready == 1'b0, "R9 busy before abort", miss_ready, 0);
    rst_ni = 1'b0;
    #1;
    idle_outs("R9 abort");
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (8) begin
      @(negedge clk);
      idle_outs("R9 stays idle");
    end
    refill(26'h0C0FFEE, 2'd1, 1'b0);
    refill(26'h0000001, 2'd3, 1'b0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule